// File: doc/BRIEF.md
# Narrow SDRAM Bus Access Sequencer

This block sits between a CPU-side load/store port and an SDRAM device whose data bus is 16 bits wide. A request carries a byte address, a direction, a size (byte, halfword or word) and 32-bit write data. The block accepts it through a valid/ready handshake and runs one 16-bit access for a byte or halfword, or two for a word. Each access is a fixed command train: activate the row, issue the column read or write, close the bank with a precharge. Reads are captured a fixed number of cycles after the read command and merged into a 32-bit result. A one-cycle `done` pulse marks the end of the request and carries the read data.

The request address is split from the top down into bank, row and column fields. Address bit 0 selects the byte within a halfword. The column is counted in halfwords. Both byte-lane masks are active low: a low mask lets that lane transfer. Timing gaps between commands are fixed single cycles. Refresh, initialisation and timing-parameter control sit elsewhere in the controller.

Top module: `narrow_sdram_seq`

## Requirements
- R1: `req_ready` is high only while no request is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `done` is high for exactly one cycle at the end of the request, and `req_ready` is high again in the cycle after `done`.
- R2: The pins (`sd_cs_n`, `sd_ras_n`, `sd_cas_n`, `sd_we_n`) carry: activate = 0,0,1,1; read = 0,1,0,1; write = 0,1,0,0; precharge = 0,0,1,0; no-operation = 0,1,1,1. While idle, and after reset, `sd_cs_n` is 1 (deselect).
- R3: Each access is activate, one no-op, then read or write. A write is followed by one no-op and a read by RD_LAT no-ops. Then come a precharge and one closing no-op. Activate puts the row (address bits [22:10]) on `sd_a`, and `sd_ba` holds the bank (address bits [24:23]) throughout. A single access takes 6 cycles for a write and 7 for a read, counted from the cycle after acceptance up to and including `done`.
- R4: Read and write commands put the halfword column (address bits [9:1]) on `sd_a[8:0]` with `sd_a[10]` low. The precharge drives `sd_a[10]` low, which closes only the addressed bank.
- R5: A word request (size code 2) ignores address bits [1:0]. It runs two accesses back to back, the first at the column with bit 0 cleared carrying data bits [15:0], the second at the column with bit 0 set carrying bits [31:16]. Each access starts with its own activate.
- R6: A halfword request (size code 1) runs one access with `sd_dqm` = 2'b00 and data bits [15:0] on all 16 data pins.
- R7: A byte write (size code 0) takes the byte from `req_wdata[7:0]`. With address bit 0 = 0 it drives `sd_dqm` = 2'b10 (bit 1 is the high lane) and the byte on `sd_dq_out[7:0]`. With address bit 0 = 1 it drives `sd_dqm` = 2'b01 and the byte on `sd_dq_out[15:8]`.
- R8: A byte read drives `sd_dqm` = 2'b00. It returns `sd_dq_in[7:0]` when address bit 0 is 0 and `sd_dq_in[15:8]` when it is 1, in `rdata[7:0]`, with bits [31:8] zero.
- R9: Read data is taken from `sd_dq_in` in the cycle RD_LAT cycles after the read command. `rdata` is valid while `done` is high, and a halfword read returns zeros in bits [31:16].
- R10: `sd_dq_oe` is high only in a write command cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 25 | Byte address: bank [24:23], row [22:10], column [9:1], byte [0] |
| req_wdata | input | 32 | Write data, right-aligned for byte and halfword |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data, valid with `done` |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Row / column address, bit 10 is auto-precharge / all-bank select |
| sd_dqm | output | 2 | Lane masks, active low enable; bit 1 high lane, bit 0 low lane |
| sd_dq_out | output | 16 | Write data to the pins |
| sd_dq_oe | output | 1 | Data pin output enable |
| sd_dq_in | input | 16 | Read data from the pins |

## Verification
The bench builds the block with its default parameters: 2 bank bits, 13 row bits, 9 column bits and a read latency of 2. The bench's small memory model keys storage by bank, open row and column, so writes to the same column in bank 0, bank 3 and row 1 are told apart. The model returns a poison value outside the latency slot, so a read captured one cycle early or late comes back wrong. With a latency of 2, each read access has two no-op cycles before its precharge, so a read and a write differ in length by exactly one cycle.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
    CMD_PRE, CMD_PALL, CMD_REF, CMD_MRS
  } nsq_cmd_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } nsq_size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_GAP, ST_RW, ST_WAIT, ST_PRE, ST_TAIL
  } nsq_state_e;

endpackage

// File: rtl/nsq_cmd_enc.sv
module nsq_cmd_enc
  import nsq_pkg::*;
#(
  parameter int A_W    = 13,
  parameter int BANK_W = 2
) (
  input  nsq_cmd_e          cmd,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [A_W-1:0]    a_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [A_W-1:0]    a_out
);
  localparam int AP_BIT = 10;

  logic [3:0] pins;

  always_comb begin
    case (cmd)
      CMD_DESEL: pins = 4'b1111;
      CMD_ACT:   pins = 4'b0011;
      CMD_RD:    pins = 4'b0101;
      CMD_WR:    pins = 4'b0100;
      CMD_PRE,
      CMD_PALL:  pins = 4'b0010;
      CMD_REF:   pins = 4'b0001;
      CMD_MRS:   pins = 4'b0000;
      default:   pins = 4'b0111;
    endcase
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba    = bank_in;
    a_out = a_in;
    if (cmd == CMD_RD || cmd == CMD_WR || cmd == CMD_PRE) a_out[AP_BIT] = 1'b0;
    if (cmd == CMD_PALL) a_out[AP_BIT] = 1'b1;
  end

endmodule

// File: rtl/nsq_lane.sv
module nsq_lane
  import nsq_pkg::*;
#(
  parameter int DQ_W = 16,
  localparam int DW  = 2 * DQ_W
) (
  input  nsq_size_e       size,
  input  logic            we,
  input  logic            byte_hi,
  input  logic            upper,
  input  logic [DW-1:0]   wdata,
  input  logic [DQ_W-1:0] dq_in,
  input  logic [DW-1:0]   rdata_q,
  output logic [1:0]      dqm,
  output logic [DQ_W-1:0] dq_out,
  output logic [DW-1:0]   rdata_nxt
);

  always_comb begin
    dqm = 2'b00;
    if (we && size == SZ_BYTE) dqm = byte_hi ? 2'b01 : 2'b10;

    case (size)
      SZ_BYTE: dq_out = {wdata[7:0], wdata[7:0]};
      SZ_WORD: dq_out = upper ? wdata[DW-1:DQ_W] : wdata[DQ_W-1:0];
      default: dq_out = wdata[DQ_W-1:0];
    endcase

    case (size)
      SZ_BYTE: rdata_nxt = {{(DW-8){1'b0}}, byte_hi ? dq_in[15:8] : dq_in[7:0]};
      SZ_WORD: rdata_nxt = upper ? {dq_in, rdata_q[DQ_W-1:0]}
                                 : {rdata_q[DW-1:DQ_W], dq_in};
      default: rdata_nxt = {{DQ_W{1'b0}}, dq_in};
    endcase
  end

endmodule

// File: rtl/narrow_sdram_seq.sv
module narrow_sdram_seq
  import nsq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int RD_LAT = 2,
  localparam int ADDR_W = 1 + COL_W + ROW_W + BANK_W,
  localparam int DQ_W   = 16,
  localparam int DW     = 2 * DQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [1:0]        sd_dqm,
  output logic [DQ_W-1:0]   sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DQ_W-1:0]   sd_dq_in
);
  localparam int CNT_W = $clog2(RD_LAT + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  nsq_state_e        state_q, state_d;
  logic              we_q, we_d, upper_q, upper_d;
  nsq_size_e         size_q, size_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DW-1:0]     wdata_q, wdata_d, rdata_q, rdata_d, rdata_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              last_acc;

  assign last_acc = (size_q != SZ_WORD) || upper_q;

  always_comb begin
    state_d = state_q;
    we_d    = we_q;
    size_d  = size_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    upper_d = upper_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        we_d    = req_we;
        size_d  = nsq_size_e'(req_size);
        addr_d  = req_addr;
        wdata_d = req_wdata;
        upper_d = 1'b0;
        rdata_d = '0;
        state_d = ST_ACT;
      end
      ST_ACT:  state_d = ST_GAP;
      ST_GAP:  state_d = ST_RW;
      ST_RW: begin
        cnt_d   = we_q ? '0 : CNT_W'(RD_LAT - 1);
        state_d = ST_WAIT;
      end
      ST_WAIT: if (cnt_q == '0) begin
        if (!we_q) rdata_d = rdata_nxt;
        state_d = ST_PRE;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
      ST_PRE:  state_d = ST_TAIL;
      ST_TAIL: if (last_acc) begin
        state_d = ST_IDLE;
      end else begin
        upper_d = 1'b1;
        state_d = ST_ACT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      size_q  <= SZ_BYTE;
      addr_q  <= '0;
      wdata_q <= '0;
      upper_q <= 1'b0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      size_q  <= size_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      upper_q <= upper_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
    end
  end

  // command and address selection
  nsq_cmd_e         cmd;
  logic [ROW_W-1:0] a_sel;
  logic [COL_W-1:0] col;

  always_comb begin
    col = addr_q[COL_W:1];
    if (size_q == SZ_WORD) col[0] = upper_q;
    a_sel = '0;
    case (state_q)
      ST_IDLE: cmd = CMD_DESEL;
      ST_ACT: begin
        cmd   = CMD_ACT;
        a_sel = addr_q[COL_W+ROW_W:COL_W+1];
      end
      ST_RW: begin
        cmd               = we_q ? CMD_WR : CMD_RD;
        a_sel[COL_W-1:0]  = col;
      end
      ST_PRE:  cmd = CMD_PRE;
      default: cmd = CMD_NOP;
    endcase
  end

  nsq_cmd_enc #(.A_W(ROW_W), .BANK_W(BANK_W)) u_enc (
    .cmd     (cmd),
    .bank_in (addr_q[ADDR_W-1 -: BANK_W]),
    .a_in    (a_sel),
    .cs_n    (sd_cs_n),
    .ras_n   (sd_ras_n),
    .cas_n   (sd_cas_n),
    .we_n    (sd_we_n),
    .ba      (sd_ba),
    .a_out   (sd_a)
  );

  nsq_lane #(.DQ_W(DQ_W)) u_lane (
    .size      (size_q),
    .we        (we_q),
    .byte_hi   (addr_q[0]),
    .upper     (upper_q),
    .wdata     (wdata_q),
    .dq_in     (sd_dq_in),
    .rdata_q   (rdata_q),
    .dqm       (sd_dqm),
    .dq_out    (sd_dq_out),
    .rdata_nxt (rdata_nxt)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_TAIL) && last_acc;
  assign rdata     = rdata_q;
  assign sd_dq_oe  = (state_q == ST_RW) && we_q;

  // checks on the pin behaviour
  logic pin_act, pin_rd, pin_wr, pin_pre, pin_nop;
  assign pin_act = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011;
  assign pin_rd  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0101;
  assign pin_wr  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0100;
  assign pin_pre = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010;
  assign pin_nop = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111;

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> !done);
  assert_ready_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> req_ready);
  assert_act_gap_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    pin_act |=> pin_nop);
  assert_pre_gap_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    pin_pre |=> pin_nop);
  assert_col_a10_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pin_rd || pin_wr || pin_pre) |-> !sd_a[10]);
  assert_read_mask_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    pin_rd |-> (sd_dqm == 2'b00));
  assert_oe_write_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    sd_dq_oe |-> pin_wr);

endmodule

// File: tb/narrow_sdram_seq_bench.sv
module narrow_sdram_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_we, done;
  logic [1:0]  req_size;
  logic [24:0] req_addr;
  logic [31:0] req_wdata, rdata;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba, sd_dqm;
  logic [12:0] sd_a;
  logic [15:0] sd_dq_out, sd_dq_in;

  narrow_sdram_seq u_narrow_sdram_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and trace recorder, sampled on the falling edge
  logic [15:0] mem [int];
  logic [12:0] row_open [0:3];
  bit          s1_v, s2_v;
  int          s1_k, s2_k;
  bit          trace_on = 0;
  int          tn = 0;
  logic [3:0]  t_cmd [0:15];
  logic [12:0] t_a   [0:15];
  logic [1:0]  t_ba  [0:15];
  logic [1:0]  t_dqm [0:15];
  logic [15:0] t_dq  [0:15];
  logic        t_oe  [0:15];
  logic        t_rdy [0:15];

  initial begin
    sd_dq_in = 16'hDEAD;
    s1_v = 0; s2_v = 0; s1_k = 0; s2_k = 0;
    for (int i = 0; i < 4; i++) row_open[i] = '0;
  end

  always @(negedge clk) begin
    logic [3:0]  pins;
    logic [15:0] w;
    int          key;
    pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    key  = int'({sd_ba, row_open[sd_ba], sd_a[8:0]});
    if (s2_v) sd_dq_in = mem.exists(s2_k) ? mem[s2_k] : 16'h0000;
    else      sd_dq_in = 16'hDEAD;
    s2_v = s1_v; s2_k = s1_k;
    s1_v = (pins == 4'b0101); s1_k = key;
    if (pins == 4'b0011) row_open[sd_ba] = sd_a;
    if (pins == 4'b0100) begin
      w = mem.exists(key) ? mem[key] : 16'h0000;
      if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
      if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
      mem[key] = w;
    end
    if (trace_on && tn < 16) begin
      t_cmd[tn] = pins; t_a[tn] = sd_a; t_ba[tn] = sd_ba; t_dqm[tn] = sd_dqm;
      t_dq[tn] = sd_dq_out; t_oe[tn] = sd_dq_oe; t_rdy[tn] = req_ready;
      tn++;
    end
  end

  task automatic do_req(input logic we, input logic [1:0] sz, input logic [24:0] addr,
                        input logic [31:0] wd, input bit trace,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    if (trace) begin tn = 0; trace_on = 1; end
    cyc = 0; rd = '0;
    while (cyc < 40) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (done) begin rd = rdata; break; end
    end
    @(posedge clk);
    trace_on = 0;
  endtask

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [24:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 2'd2, 25'h0000100, 32'h11223344, 32'h0},
    '{1'b0, 2'd0, 25'h0000100, 32'h0,        32'h00000044},
    '{1'b0, 2'd0, 25'h0000101, 32'h0,        32'h00000033},
    '{1'b0, 2'd1, 25'h0000102, 32'h0,        32'h00001122},
    '{1'b1, 2'd0, 25'h0000103, 32'h0000005A, 32'h0},
    '{1'b0, 2'd2, 25'h0000100, 32'h0,        32'h5A223344},
    '{1'b1, 2'd1, 25'h0000100, 32'h0000BEEF, 32'h0},
    '{1'b1, 2'd0, 25'h0000100, 32'h00000077, 32'h0},
    '{1'b0, 2'd2, 25'h0000100, 32'h0,        32'h5A22BE77},
    '{1'b1, 2'd2, 25'h0000004, 32'h01020304, 32'h0},
    '{1'b1, 2'd2, 25'h1800004, 32'hCAFEF00D, 32'h0},
    '{1'b1, 2'd2, 25'h0000404, 32'h0BADF00D, 32'h0},
    '{1'b0, 2'd2, 25'h0000004, 32'h0,        32'h01020304},
    '{1'b0, 2'd2, 25'h1800004, 32'h0,        32'hCAFEF00D},
    '{1'b0, 2'd2, 25'h0000406, 32'h0,        32'h0BADF00D},
    '{1'b0, 2'd1, 25'h1800006, 32'h0,        32'h0000CAFE}
  };

  bit finished = 0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    int          cyc;
    req_valid = 0; req_we = 0; req_size = 0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state: R1, R2, R10
    chk(req_ready === 1'b1, "R1 ready after reset", {31'b0, req_ready}, 1);
    chk(done === 1'b0, "R1 done low after reset", {31'b0, done}, 0);
    chk(sd_cs_n === 1'b1, "R2 deselect when idle", {31'b0, sd_cs_n}, 1);
    chk(sd_dq_oe === 1'b0, "R10 oe low when idle", {31'b0, sd_dq_oe}, 0);

    // vector table: R3 cycle counts, R5/R6/R7/R8/R9 data
    for (int i = 0; i < NV; i++) begin
      int exp_cyc;
      do_req(VECS[i].we, VECS[i].sz, VECS[i].addr, VECS[i].wd, 0, rd, cyc);
      exp_cyc = (VECS[i].sz == 2'd2 ? 2 : 1) * (VECS[i].we ? 6 : 7);
      chk(cyc == exp_cyc, "R3 request length", cyc, exp_cyc);
      if (!VECS[i].we) chk(rd === VECS[i].exp, "R9 read data", rd, VECS[i].exp);
    end

    // byte write, high lane, bank 1 row 3 col 1
    do_req(1'b1, 2'd0, 25'h0800C03, 32'h000000A7, 1, rd, cyc);
    chk(t_cmd[0] == 4'b0011, "R2 activate pins", {28'b0, t_cmd[0]}, 32'h3);
    chk(t_a[0] == 13'd3 && t_ba[0] == 2'd1, "R3 row and bank on activate", {t_ba[0], t_a[0]}, {2'd1, 13'd3});
    chk(t_cmd[1] == 4'b0111, "R2 nop pins", {28'b0, t_cmd[1]}, 32'h7);
    chk(t_rdy[1] == 1'b0, "R1 not ready while busy", {31'b0, t_rdy[1]}, 0);
    chk(t_cmd[2] == 4'b0100, "R2 write pins", {28'b0, t_cmd[2]}, 32'h4);
    chk(t_a[2] == 13'h001, "R4 column with A10 low", {19'b0, t_a[2]}, 1);
    chk(t_dqm[2] == 2'b01, "R7 high lane mask", {30'b0, t_dqm[2]}, 1);
    chk(t_dq[2][15:8] == 8'hA7, "R7 byte on high lane", {16'b0, t_dq[2]}, 32'hA700);
    chk(t_oe[2] && !t_oe[1] && !t_oe[3], "R10 oe only on write", {29'b0, t_oe[1], t_oe[2], t_oe[3]}, 32'h2);
    chk(t_cmd[4] == 4'b0010 && !t_a[4][10] && t_ba[4] == 2'd1, "R4 bank precharge", {t_cmd[4], t_a[4][10], t_ba[4]}, {4'h2, 1'b0, 2'd1});
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1, "R1 done single cycle then ready", {done, req_ready}, 32'h1);

    // byte write, low lane
    do_req(1'b1, 2'd0, 25'h0800C02, 32'h0000003C, 1, rd, cyc);
    chk(t_dqm[2] == 2'b10, "R7 low lane mask", {30'b0, t_dqm[2]}, 2);
    chk(t_dq[2][7:0] == 8'h3C, "R7 byte on low lane", {16'b0, t_dq[2]}, 32'h3C);

    // byte read, high lane
    do_req(1'b0, 2'd0, 25'h0800C03, 32'h0, 1, rd, cyc);
    chk(t_cmd[2] == 4'b0101, "R2 read pins", {28'b0, t_cmd[2]}, 32'h5);
    chk(t_dqm[2] == 2'b00, "R8 both masks on byte read", {30'b0, t_dqm[2]}, 0);
    chk(t_cmd[3] == 4'b0111 && t_cmd[4] == 4'b0111 && t_cmd[5] == 4'b0010, "R3 read latency gap before precharge",
        {t_cmd[3], t_cmd[4], t_cmd[5]}, 32'h772);
    chk(rd === 32'h000000A7, "R8 byte read high lane zero-extended", rd, 32'hA7);

    // halfword read of the two bytes
    do_req(1'b0, 2'd1, 25'h0800C02, 32'h0, 1, rd, cyc);
    chk(t_dqm[2] == 2'b00, "R6 halfword masks", {30'b0, t_dqm[2]}, 0);
    chk(rd === 32'h0000A73C, "R9 halfword read zero-filled", rd, 32'hA73C);

    // word write: two ordered accesses
    do_req(1'b1, 2'd2, 25'h0800C08, 32'h89ABCDEF, 1, rd, cyc);
    chk(t_a[2] == 13'd4 && t_dq[2] == 16'hCDEF, "R5 first half low bits", {t_a[2], t_dq[2]}, {13'd4, 16'hCDEF});
    chk(t_cmd[6] == 4'b0011, "R5 second activate", {28'b0, t_cmd[6]}, 32'h3);
    chk(t_a[8] == 13'd5 && t_dq[8] == 16'h89AB && t_oe[8], "R5 second half high bits", {t_a[8], t_dq[8]}, {13'd5, 16'h89AB});
    chk(t_dqm[2] == 2'b00, "R6 word halves use both lanes", {30'b0, t_dqm[2]}, 0);

    // word read with address bit 1 set: ignored
    do_req(1'b0, 2'd2, 25'h0800C0A, 32'h0, 1, rd, cyc);
    chk(t_a[2] == 13'd4 && t_a[9] == 13'd5, "R5 word columns ignore addr bit 1", {t_a[2], t_a[9]}, {13'd4, 13'd5});
    chk(rd === 32'h89ABCDEF, "R5 word read merged", rd, 32'h89ABCDEF);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule